// File: doc/BRIEF.md
# ADC Conversion Interrupt Flag Controller

This block sits between the end-of-conversion events of an analog-to-digital converter and the interrupt fabric. It serves a parameterised number of interrupt channels, four by default. Each channel has a latched pending flag, an overflow flag that records lost interrupts, and a continue-mode bit. A conversion event on a channel raises a one-cycle interrupt pulse. The pending flag gates that pulse unless continue mode is on. A small register port sets the mode bits, clears the pending and overflow flags with write-one-to-clear strobes, and reads back all three per-channel fields.

An event that arrives in the same cycle as a software clear beats the clear. The flag stays set and the overflow flag records the collision, so an interrupt is never dropped without a record. Software checks the overflow field after a clear and repeats the clear when it finds the overflow set.

Top module: `adc_irq_flag_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every pending flag, every overflow flag and every mode bit.
- R2: An event on a channel whose pending flag is clear drives that channel's interrupt output high in the same cycle, and the pending flag reads as set from the next cycle.
- R3: With the mode bit at 0 and the pending flag set, an event produces no interrupt pulse.
- R4: With the mode bit at 1, every event produces an interrupt pulse in its own cycle, whatever the pending flag holds.
- R5: A write to select 1 clears the pending flag of each channel whose data bit is 1. Channels whose data bit is 0 keep their flag.
- R6: An event on a channel whose pending flag is already set sets that channel's overflow flag on the next edge. This happens in either mode.
- R7: When an event and a pending-flag clear hit the same channel in one cycle, the pending flag stays set. If the flag was set before, the overflow flag is also set.
- R8: A write to select 2 clears the overflow flag of each channel whose data bit is 1. Channels whose data bit is 0 keep their overflow flag.
- R9: When an event meets a set pending flag in the same cycle as an overflow clear on that channel, the overflow flag ends up set.
- R10: Reads are combinational on the select. Select 0 returns the mode bits, select 1 the pending flags, select 2 the overflow flags and select 3 returns zero. Channel 1 is in bit 0. A write to select 0 loads the mode bits from the data.
- R11: An event, clear or mode write addressed to one channel never changes another channel's state or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| conv_evt | input | NUM_CH | End-of-conversion pulse per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Write select: 0 mode, 1 pending clear, 2 overflow clear |
| reg_wdata | input | NUM_CH | Write data, one bit per channel |
| reg_rsel | input | 2 | Read select |
| reg_rdata | output | NUM_CH | Read data for the selected field |
| irq_pulse | output | NUM_CH | Interrupt pulse per channel |

## Verification
The assertions assume that an event pulse and a write strobe are plain one-cycle levels sampled at the clock edge. They also assume that no event is driven while reset is high. The stimulus keeps events low during reset. Every input changes one time unit after a rising edge, and the directed part forces the exact collisions between event, pending clear and overflow clear on one channel. A random phase then mixes all three on all channels and rotates the read select, so every field is compared against the bench model.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_MODE = 2'd0,
      SEL_PEND = 2'd1,
      SEL_OVF  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/adc_irq_chan.sv
module adc_irq_chan (
   input  logic clk,
   input  logic rst,
   input  logic evt,
   input  logic cont_mode,
   input  logic pend_clr,
   input  logic ovf_clr,
   output logic pend_q,
   output logic ovf_q,
   output logic irq
);
   logic lost;

   assign lost = evt & pend_q;
   assign irq  = evt & (cont_mode | ~pend_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (evt)
            pend_q <= 1'b1;
         else if (pend_clr)
            pend_q <= 1'b0;
         if (lost)
            ovf_q <= 1'b1;
         else if (ovf_clr)
            ovf_q <= 1'b0;
      end
   end

   assert_flag_sets_R2: assert property (@(posedge clk) disable iff (rst)
      evt |=> pend_q);
   assert_gated_R3: assert property (@(posedge clk) disable iff (rst)
      (pend_q && !cont_mode) |-> !irq);
   assert_cont_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      (evt && cont_mode) |-> irq);
   assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (pend_clr && !evt) |=> !pend_q);
   assert_lost_R6: assert property (@(posedge clk) disable iff (rst)
      (evt && pend_q) |=> ovf_q);
   assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (ovf_clr && !(evt && pend_q)) |=> !ovf_q);
endmodule

// File: rtl/adc_irq_regs.sv
module adc_irq_regs
   import adc_irq_pkg::*;
#(
   parameter int NUM_CH        = 4,
   parameter bit RD_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [NUM_CH-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   input  logic [NUM_CH-1:0] pend,
   input  logic [NUM_CH-1:0] ovf,
   output logic [NUM_CH-1:0] mode_q,
   output logic [NUM_CH-1:0] pend_clr,
   output logic [NUM_CH-1:0] ovf_clr,
   output logic [NUM_CH-1:0] rdata
);
   reg_sel_e          wsel_e, rsel_e;
   logic [NUM_CH-1:0] rd_mux;

   assign wsel_e   = reg_sel_e'(wsel);
   assign rsel_e   = reg_sel_e'(rsel);
   assign pend_clr = (wr && wsel_e == SEL_PEND) ? wdata : '0;
   assign ovf_clr  = (wr && wsel_e == SEL_OVF)  ? wdata : '0;

   always_ff @(posedge clk) begin
      if (rst)
         mode_q <= '0;
      else if (wr && wsel_e == SEL_MODE)
         mode_q <= wdata;
   end

   always_comb begin
      unique case (rsel_e)
         SEL_MODE: rd_mux = mode_q;
         SEL_PEND: rd_mux = pend;
         SEL_OVF:  rd_mux = ovf;
         default:  rd_mux = '0;
      endcase
   end

   generate
      if (RD_REGISTERED) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (rst) rdata <= '0;
            else     rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate

   assert_mode_load_R10: assert property (@(posedge clk) disable iff (rst)
      (wr && wsel == 2'd0) |=> (mode_q == $past(wdata)));
endmodule

// File: rtl/adc_irq_flag_ctrl.sv
module adc_irq_flag_ctrl
   import adc_irq_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] conv_evt,
   input  logic              reg_wr,
   input  logic [SEL_W-1:0]  reg_wsel,
   input  logic [NUM_CH-1:0] reg_wdata,
   input  logic [SEL_W-1:0]  reg_rsel,
   output logic [NUM_CH-1:0] reg_rdata,
   output logic [NUM_CH-1:0] irq_pulse
);
   logic [NUM_CH-1:0] mode_q, pend_clr, ovf_clr, pend_q, ovf_q;

   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
         $error("NUM_CH must lie between 1 and 32");
      end
   endgenerate

   adc_irq_regs #(.NUM_CH(NUM_CH), .RD_REGISTERED(1'b0)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr       (reg_wr),
      .wsel     (reg_wsel),
      .wdata    (reg_wdata),
      .rsel     (reg_rsel),
      .pend     (pend_q),
      .ovf      (ovf_q),
      .mode_q   (mode_q),
      .pend_clr (pend_clr),
      .ovf_clr  (ovf_clr),
      .rdata    (reg_rdata)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         adc_irq_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .evt       (conv_evt[c]),
            .cont_mode (mode_q[c]),
            .pend_clr  (pend_clr[c]),
            .ovf_clr   (ovf_clr[c]),
            .pend_q    (pend_q[c]),
            .ovf_q     (ovf_q[c]),
            .irq       (irq_pulse[c])
         );
      end
   endgenerate

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (mode_q == '0 && pend_q == '0 && ovf_q == '0));
   assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      (conv_evt == '0 && !reg_wr) |=> $stable(pend_q) && $stable(ovf_q) && $stable(mode_q));
endmodule

// File: tb/adc_irq_flag_ctrl_bench.sv
module adc_irq_flag_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NCH-1:0] conv_evt = '0;
   logic           reg_wr = 1'b0;
   logic [1:0]     reg_wsel = '0;
   logic [NCH-1:0] reg_wdata = '0;
   logic [1:0]     reg_rsel = '0;
   logic [NCH-1:0] reg_rdata, irq_pulse;

   int m_pend[NCH];
   int m_ovf[NCH];
   int m_mode[NCH];
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_irq_flag_ctrl #(.NUM_CH(NCH)) u_adc_irq_flag_ctrl (
      .clk(clk), .rst(rst), .conv_evt(conv_evt), .reg_wr(reg_wr),
      .reg_wsel(reg_wsel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
      .reg_rdata(reg_rdata), .irq_pulse(irq_pulse)
   );

   task automatic chk(string tag, string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [NCH-1:0] pack(int which, logic [1:0] sel);
      logic [NCH-1:0] v = '0;
      for (int c = 0; c < NCH; c++) begin
         case (sel)
            2'd0: v[c] = (m_mode[c] != 0);
            2'd1: v[c] = (m_pend[c] != 0);
            2'd2: v[c] = (m_ovf[c] != 0);
            default: v[c] = 1'b0;
         endcase
      end
      return (which == 0) ? v : '0;
   endfunction

   // one clock of stimulus, entered 1 time unit after a rising edge
   task automatic cyc(string tag, logic [NCH-1:0] e, logic w, logic [1:0] ws,
                      logic [NCH-1:0] wd, logic [1:0] rs);
      logic [NCH-1:0] exp_irq;
      conv_evt = e; reg_wr = w; reg_wsel = ws; reg_wdata = wd; reg_rsel = rs;
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
         exp_irq[c] = e[c] && (m_mode[c] != 0 || m_pend[c] == 0);
      chk(tag, "irq", irq_pulse, exp_irq);
      chk(tag, "read", reg_rdata, pack(0, rs));
      @(posedge clk);
      for (int c = 0; c < NCH; c++) begin
         bit pc = w && ws == 2'd1 && wd[c];
         bit oc = w && ws == 2'd2 && wd[c];
         int np = (e[c] || (m_pend[c] != 0 && !pc)) ? 1 : 0;
         int no = ((e[c] && m_pend[c] != 0) || (m_ovf[c] != 0 && !oc)) ? 1 : 0;
         m_pend[c] = np;
         m_ovf[c] = no;
         if (w && ws == 2'd0) m_mode[c] = wd[c] ? 1 : 0;
      end
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1; conv_evt = '0; reg_wr = 1'b0;
      repeat (2) @(posedge clk);
      for (int c = 0; c < NCH; c++) begin
         m_pend[c] = 0; m_ovf[c] = 0; m_mode[c] = 0;
      end
      #1;
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset();
      // dirty the state, then reset again: R1
      cyc("R10", 4'b0000, 1'b1, 2'd0, 4'b1111, 2'd0);
      cyc("R2", 4'b1111, 1'b0, 2'd0, 4'b0000, 2'd0);
      cyc("R6", 4'b1111, 1'b0, 2'd0, 4'b0000, 2'd2);
      do_reset();
      cyc("R1", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd0);
      cyc("R1", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd1);
      cyc("R1", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd2);
      // R2: first event on channel 1
      cyc("R2", 4'b0001, 1'b0, 2'd0, 4'b0000, 2'd1);
      cyc("R2", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd1);
      // R3 and R6: second event is gated and recorded as lost
      cyc("R3", 4'b0001, 1'b0, 2'd0, 4'b0000, 2'd2);
      cyc("R6", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd2);
      // R5: zero write keeps flag, one write clears it
      cyc("R5", 4'b0000, 1'b1, 2'd1, 4'b1110, 2'd1);
      cyc("R5", 4'b0000, 1'b1, 2'd1, 4'b0001, 2'd1);
      cyc("R5", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd1);
      // R8: overflow clear
      cyc("R8", 4'b0000, 1'b1, 2'd2, 4'b0000, 2'd2);
      cyc("R8", 4'b0000, 1'b1, 2'd2, 4'b0001, 2'd2);
      cyc("R8", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd2);
      // R7: event collides with pending clear on channel 2
      cyc("R7", 4'b0010, 1'b0, 2'd0, 4'b0000, 2'd1);
      cyc("R7", 4'b0010, 1'b1, 2'd1, 4'b0010, 2'd1);
      cyc("R7", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd1);
      cyc("R7", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd2);
      cyc("R7", 4'b0000, 1'b1, 2'd1, 4'b0010, 2'd1);
      cyc("R7", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd1);
      // R9: event collides with overflow clear on channel 3
      cyc("R9", 4'b0100, 1'b0, 2'd0, 4'b0000, 2'd2);
      cyc("R9", 4'b0100, 1'b1, 2'd2, 4'b0100, 2'd2);
      cyc("R9", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd2);
      // R4: continue mode on channel 3 pulses every event
      cyc("R4", 4'b0000, 1'b1, 2'd0, 4'b0100, 2'd0);
      cyc("R4", 4'b0100, 1'b0, 2'd0, 4'b0000, 2'd0);
      cyc("R4", 4'b0100, 1'b0, 2'd0, 4'b0000, 2'd1);
      // R11: channel 4 event while channel 1 state is cleared
      cyc("R11", 4'b1000, 1'b1, 2'd1, 4'b0001, 2'd1);
      cyc("R11", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd1);
      cyc("R10", 4'b0000, 1'b0, 2'd0, 4'b0000, 2'd3);
      // random mix of all operations on all channels
      for (int i = 0; i < 400; i++) begin
         logic [NCH-1:0] e = NCH'($urandom) & NCH'($urandom);
         logic w = ($urandom % 3) == 0;
         logic [1:0] ws = 2'($urandom % 3);
         cyc("R11", e, w, ws, NCH'($urandom), 2'(i % 4));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule